// File: doc/BRIEF.md
# Dual 16-bit Event Timer

This block holds two independent 16-bit down-counters that a host programs through a byte-wide register window. Each timer has a mode byte, a reload value written one byte at a time, start and stop strobes that carry no data, and one output line. While running, a counter steps down once per prescaled tick. In the two counting modes it reloads itself on the step that reaches zero and raises its output. The output then stays high until the host reads the count.

A prescaler built from the system clock sets each timer's rate. Timer 0 can divide by 1, 2 or 64; timer 1 can divide only by 1 or 2. The host starts a timer with a write to its start offset. Every start restarts the prescaler, so the first step falls one full prescaled period after the start write. Counter reads are not latched: each byte is sampled at its own read cycle.

Top module: `dual_event_timer`

## Requirements
- R1: After reset both outputs are low, and every counter byte and both mode registers read 0x00.
- R2: A write to a counter byte updates that byte of both the reload base and the live counter. The offsets are 0x10 (timer 0 low), 0x11 (timer 0 high), 0x12 (timer 1 low) and 0x13 (timer 1 high).
- R3: Timer 0 mode sits at 0x18 and timer 1 mode at 0x19; reading either returns the stored byte. A read of any offset that is not mapped returns 0xFF.
- R4: A write to the start offset (0x15 for timer 0, 0x17 for timer 1) has an effect only when mode bits [2:0] are neither 000 nor 111. Otherwise the counter does not move.
- R5: For timer 0, mode bit 4 selects divide by 64 and takes priority over bit 3. Bit 3 selects divide by 2. With neither bit set, the divider is 1. The first step comes exactly one divided period after the start write.
- R6: Timer 1 ignores mode bit 4. Its bit 3 selects divide by 2, otherwise divide by 1.
- R7: In modes 001 and 010, a step from a count of 1 raises the output and loads the base value instead of 0. Both are visible after that clock edge.
- R8: In modes 001 and 010 the output stays high, even while the timer is stopped, until the host reads either byte of that counter. The read clears the output. If a new zero is reached in the same cycle as the read, the output stays high.
- R9: In any other running mode the counter steps through zero and wraps to 0xFFFF, and the output never rises.
- R10: A write to the stop offset (0x14 for timer 0, 0x16 for timer 1) freezes the counter. A later start resumes counting from the held value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; also the source of every count tick |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Register offset of the current access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access; a counter read clears that timer's output on this edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational from register state |
| tmr_out | output | 2 | Output line of each timer, bit 0 for timer 0 |

## Verification
The assertions assume that bus_wr and bus_rd are never high in the same cycle, and that each strobe lasts exactly one clock for one offset. The property on cleared outputs and the property on frozen counters both rely on this. The bench drives every access from a task that raises one strobe for a single cycle and returns it low. Stimulus changes only on falling edges. Count values are predicted by counting rising edges from the start write, using the divider that the mode byte selects.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int ADDR_W = 5;

    // Register window: counter bytes, stop/start strobes, mode bytes
    localparam logic [ADDR_W-1:0] OFS_CNT  = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h14;
    localparam logic [ADDR_W-1:0] OFS_MODE = 5'h18;

    // Mode byte fields
    localparam int MB_HALF = 3;
    localparam int MB_SLOW = 4;

    typedef struct packed {
        logic ld_lo;
        logic ld_hi;
        logic start;
        logic stop;
        logic rd_cnt;
        logic mode_wr;
    } chan_cmd_t;

    function automatic logic [ADDR_W-1:0] lo_addr(input int idx);
        return OFS_CNT + ADDR_W'(2 * idx);
    endfunction

    function automatic logic [ADDR_W-1:0] hi_addr(input int idx);
        return OFS_CNT + ADDR_W'(2 * idx + 1);
    endfunction

    function automatic logic [ADDR_W-1:0] stop_addr(input int idx);
        return OFS_CTRL + ADDR_W'(2 * idx);
    endfunction

    function automatic logic [ADDR_W-1:0] start_addr(input int idx);
        return OFS_CTRL + ADDR_W'(2 * idx + 1);
    endfunction

    function automatic logic [ADDR_W-1:0] mode_addr(input int idx);
        return OFS_MODE + ADDR_W'(idx);
    endfunction

    // Mode field allows a start
    function automatic logic mode_runs(input logic [2:0] m);
        return (m != 3'b000) && (m != 3'b111);
    endfunction

    // Mode field drives the output (event / periodic)
    function automatic logic mode_flags(input logic [2:0] m);
        return (m == 3'b001) || (m == 3'b010);
    endfunction

    function automatic chan_cmd_t decode(input logic [ADDR_W-1:0] a,
                                         input logic wr, input logic rd,
                                         input int idx);
        chan_cmd_t c;
        c.ld_lo   = wr && (a == lo_addr(idx));
        c.ld_hi   = wr && (a == hi_addr(idx));
        c.stop    = wr && (a == stop_addr(idx));
        c.start   = wr && (a == start_addr(idx));
        c.mode_wr = wr && (a == mode_addr(idx));
        c.rd_cnt  = rd && ((a == lo_addr(idx)) || (a == hi_addr(idx)));
        return c;
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int  SLOW_DIV = 64,
    parameter bit  HAS_SLOW = 1'b1,
    parameter int  MODE_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              running,
    input  logic [MODE_W-1:0] mode,
    output logic              tick
);
    import tmr_pkg::*;

    localparam int PW = $clog2(SLOW_DIV);

    logic [PW-1:0] pre_q;
    logic [PW-1:0] limit;

    generate
        if (HAS_SLOW) begin : g_slow
            always_comb begin
                if (mode[MB_SLOW])      limit = PW'(SLOW_DIV - 1);
                else if (mode[MB_HALF]) limit = PW'(1);
                else                    limit = '0;
            end
        end else begin : g_fast
            always_comb begin
                limit = mode[MB_HALF] ? PW'(1) : '0;
            end
        end
    endgenerate

    assign tick = running && (pre_q >= limit);

    always_ff @(posedge clk) begin
        if (rst || restart)  pre_q <= '0;
        else if (running)    pre_q <= tick ? '0 : pre_q + PW'(1);
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
    parameter int DATA_W   = 8,
    parameter int SLOW_DIV = 64,
    parameter bit HAS_SLOW = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  tmr_pkg::chan_cmd_t    cmd,
    input  logic [DATA_W-1:0]     wdata,
    output logic [2*DATA_W-1:0]   cnt_q,
    output logic [2*DATA_W-1:0]   base_q,
    output logic [DATA_W-1:0]     mode_q,
    output logic                  run_q,
    output logic                  out_q,
    output logic                  tick
);
    import tmr_pkg::*;

    localparam int CNT_W = 2 * DATA_W;

    logic start_ok;
    logic flags;
    logic loading;
    logic fire;

    assign start_ok = cmd.start && mode_runs(mode_q[2:0]);
    assign flags    = mode_flags(mode_q[2:0]);
    assign loading  = cmd.ld_lo || cmd.ld_hi;
    assign fire     = tick && !loading && flags && (cnt_q == CNT_W'(1));

    tmr_prescale #(
        .SLOW_DIV (SLOW_DIV),
        .HAS_SLOW (HAS_SLOW),
        .MODE_W   (DATA_W)
    ) u_pre (
        .clk     (clk),
        .rst     (rst),
        .restart (start_ok),
        .running (run_q),
        .mode    (mode_q),
        .tick    (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            mode_q <= '0;
            base_q <= '0;
        end else begin
            if (cmd.stop)        run_q <= 1'b0;
            else if (start_ok)   run_q <= 1'b1;
            if (cmd.mode_wr)     mode_q <= wdata;
            if (cmd.ld_lo)       base_q[DATA_W-1:0]     <= wdata;
            if (cmd.ld_hi)       base_q[CNT_W-1:DATA_W] <= wdata;
        end
    end

    // Host byte loads take precedence over a tick in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (loading) begin
            if (cmd.ld_lo) cnt_q[DATA_W-1:0]     <= wdata;
            if (cmd.ld_hi) cnt_q[CNT_W-1:DATA_W] <= wdata;
        end else if (fire) begin
            cnt_q <= base_q;
        end else if (tick) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // A new zero wins over a clearing read in the same cycle
    always_ff @(posedge clk) begin
        if (rst)                       out_q <= 1'b0;
        else if (fire)                 out_q <= 1'b1;
        else if (cmd.rd_cnt && flags)  out_q <= 1'b0;
    end

endmodule

// File: rtl/dual_event_timer.sv
module dual_event_timer #(
    parameter int DATA_W   = 8,
    parameter int N_TMR    = 2,
    parameter int SLOW_DIV = 64
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [tmr_pkg::ADDR_W-1:0]   bus_addr,
    input  logic                         bus_wr,
    input  logic                         bus_rd,
    input  logic [DATA_W-1:0]            bus_wdata,
    output logic [DATA_W-1:0]            bus_rdata,
    output logic [N_TMR-1:0]             tmr_out
);
    import tmr_pkg::*;

    localparam int CNT_W = 2 * DATA_W;

    logic [N_TMR-1:0][CNT_W-1:0]  cnt_vec;
    logic [N_TMR-1:0][CNT_W-1:0]  base_vec;
    logic [N_TMR-1:0][DATA_W-1:0] mode_vec;
    logic [N_TMR-1:0]             run_vec;
    logic [N_TMR-1:0]             tick_vec;

    generate
        for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
            chan_cmd_t cmd;
            assign cmd = decode(bus_addr, bus_wr, bus_rd, i);

            tmr_channel #(
                .DATA_W   (DATA_W),
                .SLOW_DIV (SLOW_DIV),
                .HAS_SLOW (i == 0)
            ) u_chan (
                .clk    (clk),
                .rst    (rst),
                .cmd    (cmd),
                .wdata  (bus_wdata),
                .cnt_q  (cnt_vec[i]),
                .base_q (base_vec[i]),
                .mode_q (mode_vec[i]),
                .run_q  (run_vec[i]),
                .out_q  (tmr_out[i]),
                .tick   (tick_vec[i])
            );
        end
    endgenerate

    always_comb begin
        bus_rdata = '1;
        for (int i = 0; i < N_TMR; i++) begin
            if (bus_addr == lo_addr(i))   bus_rdata = cnt_vec[i][DATA_W-1:0];
            if (bus_addr == hi_addr(i))   bus_rdata = cnt_vec[i][CNT_W-1:DATA_W];
            if (bus_addr == mode_addr(i)) bus_rdata = mode_vec[i];
        end
    end

endmodule

// File: rtl/dual_event_timer_chk.sv
module dual_event_timer_chk #(
    parameter int DATA_W = 8,
    parameter int N_TMR  = 2
) (
    input logic                               clk,
    input logic                               rst,
    input logic [tmr_pkg::ADDR_W-1:0]         bus_addr,
    input logic                               bus_wr,
    input logic                               bus_rd,
    input logic [N_TMR-1:0]                   tmr_out,
    input logic [N_TMR-1:0][2*DATA_W-1:0]     cnt_vec,
    input logic [N_TMR-1:0][2*DATA_W-1:0]     base_vec,
    input logic [N_TMR-1:0][DATA_W-1:0]       mode_vec,
    input logic [N_TMR-1:0]                   run_vec,
    input logic [N_TMR-1:0]                   tick_vec
);
    import tmr_pkg::*;

    generate
        for (genvar i = 0; i < N_TMR; i++) begin : g_chk
            logic ld_any;
            logic cnt_rd;
            logic start_wr;
            assign ld_any   = bus_wr && ((bus_addr == lo_addr(i)) || (bus_addr == hi_addr(i)));
            assign cnt_rd   = bus_rd && ((bus_addr == lo_addr(i)) || (bus_addr == hi_addr(i)));
            assign start_wr = bus_wr && (bus_addr == start_addr(i));

            AST_START_GATED: assert property (@(posedge clk) disable iff (rst)
                $rose(run_vec[i]) |-> $past(start_wr && mode_runs(mode_vec[i][2:0])));   // R4

            AST_OUT_ONLY_FLAG_MODES: assert property (@(posedge clk) disable iff (rst)
                $rose(tmr_out[i]) |-> $past(mode_flags(mode_vec[i][2:0])));             // R9

            AST_OUT_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
                $rose(tmr_out[i]) |-> $past(tick_vec[i]));                              // R7

            AST_RELOAD_ON_FIRE: assert property (@(posedge clk) disable iff (rst)
                ($rose(tmr_out[i]) && !$past(ld_any)) |-> (cnt_vec[i] == base_vec[i])); // R7

            AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
                (cnt_rd && mode_flags(mode_vec[i][2:0]) && !tick_vec[i]) |=> !tmr_out[i]); // R8

            AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
                (!run_vec[i] && !ld_any) |=> $stable(cnt_vec[i]));                      // R10
        end
    endgenerate

endmodule

bind dual_event_timer dual_event_timer_chk #(
    .DATA_W (DATA_W),
    .N_TMR  (N_TMR)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .tmr_out  (tmr_out),
    .cnt_vec  (cnt_vec),
    .base_vec (base_vec),
    .mode_vec (mode_vec),
    .run_vec  (run_vec),
    .tick_vec (tick_vec)
);

// File: tb/dual_event_timer_bench.sv
module dual_event_timer_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] tmr_out;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    dual_event_timer u_dual_event_timer (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tmr_out   (tmr_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic halt_all();
        wr(5'h14, 8'h00);
        wr(5'h16, 8'h00);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 out", 32'(tmr_out), 32'h0);
        for (int a = 5'h10; a <= 5'h13; a++) begin
            rd(5'(a), v);
            check("R1 counter byte", 32'(v), 32'h0);
        end
        rd(5'h18, v); check("R1 mode0", 32'(v), 32'h0);
        rd(5'h19, v); check("R1 mode1", 32'(v), 32'h0);
    endtask

    task automatic t_mode_regs();
        logic [7:0] v;
        wr(5'h18, 8'h5A); rd(5'h18, v); check("R3 mode0 readback", 32'(v), 32'h5A);
        wr(5'h19, 8'hC3); rd(5'h19, v); check("R3 mode1 readback", 32'(v), 32'hC3);
        rd(5'h03, v); check("R3 unmapped 0x03", 32'(v), 32'hFF);
        rd(5'h1F, v); check("R3 unmapped 0x1F", 32'(v), 32'hFF);
        wr(5'h18, 8'h00); wr(5'h19, 8'h00);
    endtask

    task automatic t_bytes();
        logic [7:0] v;
        wr(5'h10, 8'h34); wr(5'h11, 8'h12);
        wr(5'h12, 8'hCD); wr(5'h13, 8'hAB);
        rd(5'h10, v); check("R2 t0 low", 32'(v), 32'h34);
        rd(5'h11, v); check("R2 t0 high", 32'(v), 32'h12);
        rd(5'h12, v); check("R2 t1 low", 32'(v), 32'hCD);
        rd(5'h13, v); check("R2 t1 high", 32'(v), 32'hAB);
    endtask

    task automatic t_start_gate();
        logic [7:0] v;
        wr(5'h18, 8'h00); wr(5'h10, 8'h05); wr(5'h11, 8'h00);
        wr(5'h15, 8'h00); idle(10);
        rd(5'h10, v); check("R4 mode 000 no start", 32'(v), 32'h05);
        wr(5'h18, 8'h07); wr(5'h15, 8'h00); idle(10);
        rd(5'h10, v); check("R4 mode 111 no start", 32'(v), 32'h05);
        halt_all();
    endtask

    task automatic t_event_div1();
        logic [7:0] v;
        wr(5'h18, 8'h01); wr(5'h10, 8'h03); wr(5'h11, 8'h00);
        wr(5'h15, 8'h00);
        idle(1);
        rd(5'h10, v); check("R5 first step one period after start", 32'(v), 32'h02);
        idle(1);
        check("R7 output raised at zero", 32'(tmr_out[0]), 32'h1);
        rd(5'h10, v); check("R7 reload from base", 32'(v), 32'h03);
        check("R8 read clears output", 32'(tmr_out[0]), 32'h0);
        wr(5'h14, 8'h00);
        idle(5);
        rd(5'h10, v); check("R10 stop freezes count", 32'(v), 32'h01);
        wr(5'h15, 8'h00);
        idle(1);
        check("R10 resume from held count", 32'(tmr_out[0]), 32'h1);
        wr(5'h14, 8'h00);
        idle(20);
        check("R8 output sticky while stopped", 32'(tmr_out[0]), 32'h1);
        rd(5'h11, v);
        check("R8 high byte read clears output", 32'(tmr_out[0]), 32'h0);
        halt_all();
    endtask

    task automatic t_div2();
        logic [7:0] v;
        wr(5'h18, 8'h09); wr(5'h10, 8'h0A); wr(5'h11, 8'h00);
        wr(5'h15, 8'h00);
        idle(4);
        rd(5'h10, v); check("R5 divide by 2", 32'(v), 32'h08);
        halt_all();
    endtask

    task automatic t_div64();
        logic [7:0] v;
        wr(5'h18, 8'h19); wr(5'h10, 8'h05); wr(5'h11, 8'h00);
        wr(5'h15, 8'h00);
        idle(63);
        rd(5'h10, v); check("R5 div64 before period end", 32'(v), 32'h05);
        rd(5'h10, v); check("R5 div64 step at period end", 32'(v), 32'h04);
        halt_all();
    endtask

    task automatic t_timer1();
        logic [7:0] v;
        wr(5'h19, 8'h11); wr(5'h12, 8'h14); wr(5'h13, 8'h00);
        wr(5'h17, 8'h00);
        idle(4);
        rd(5'h12, v); check("R6 timer1 ignores bit4", 32'(v), 32'h10);
        check("R6 timer1 output low", 32'(tmr_out[1]), 32'h0);
        halt_all();
        wr(5'h19, 8'h09); wr(5'h12, 8'h14);
        wr(5'h17, 8'h00);
        idle(4);
        rd(5'h12, v); check("R6 timer1 divide by 2", 32'(v), 32'h12);
        halt_all();
    endtask

    task automatic t_wrap();
        logic [7:0] v;
        wr(5'h18, 8'h03); wr(5'h10, 8'h02); wr(5'h11, 8'h00);
        wr(5'h15, 8'h00);
        idle(3);
        rd(5'h10, v); check("R9 wrap low byte", 32'(v), 32'hFF);
        rd(5'h11, v); check("R9 wrap high byte", 32'(v), 32'hFF);
        check("R9 output stays low", 32'(tmr_out[0]), 32'h0);
        halt_all();
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle(4);
        rst = 1'b0;
        idle(1);
        t_reset();
        t_mode_regs();
        t_bytes();
        t_start_gate();
        t_event_div1();
        t_div2();
        t_div64();
        t_timer1();
        t_wrap();
        idle(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule